// File: doc/BRIEF.md
# Direction-Switched Endpoint FIFO Port

This block is the processor-side data window of a USB device endpoint. One bus address is shared by both transfer directions. When the selected endpoint is set up for host-to-device traffic, a read of that address takes the next word out of the receive FIFO. When the endpoint is set up for device-to-host traffic, a write to the same address places a word into the transmit FIFO. An access that runs against the configured direction moves no data.

Each access is counted once, on the rising edge of its strobe. Two accepted accesses must lie at least `MIN_GAP` clock cycles apart; an access that comes too early is dropped and reported. A byte mode narrows the data path to the low eight bits. A read from an empty receive FIFO returns zero. A write to a full transmit FIFO is dropped and sets a sticky overflow flag. The FIFOs themselves are outside the block: it drives a push strobe with data and a pop strobe, and it observes the full and empty flags.

Top module: `efpPort`

## Requirements
- R1: Only an access whose `busAddr` equals `PORT_ADDR` (default 0x44) is acted on. An access at any other address pushes nothing, pops nothing, leaves `busRdata` unchanged and does not raise `tooSoon`.
- R2: With `epDirIn`=0 (receive direction), an accepted read with `rxEmpty`=0 drives `rxPop` high for exactly that cycle. On the next clock edge `busRdata` takes the value of `rxData`.
- R3: With `epDirIn`=1 (transmit direction), an accepted write with `txFull`=0 drives `txPush` high for exactly that cycle, with `txData` equal to `busWdata`.
- R4: A read while `epDirIn`=1, or a write while `epDirIn`=0, pushes and pops nothing. Such a read loads zero into `busRdata`.
- R5: With `epByteMode`=1, only bits [7:0] carry data. `txData[15:8]` is zero on a push, and `busRdata[15:8]` is zero after a read.
- R6: An access is accepted only when at least `MIN_GAP` cycles have passed since the last accepted access (default 50, which is 200 ns at 250 MHz). An access that comes earlier has no effect at all, and `tooSoon` is high for the one cycle after it.
- R7: An accepted receive-direction read while `rxEmpty`=1 does not pop and loads zero into `busRdata`.
- R8: An accepted transmit-direction write while `txFull`=1 does not push, and it sets `txOverflow`. `txOverflow` then stays high until reset.
- R9: A strobe held high for several cycles counts as one access only.
- R10: When both strobes rise together, only the strobe that matches `epDirIn` takes effect. Together they count as one access for the spacing rule.
- R11: After reset, `busRdata`, `txOverflow` and `tooSoon` are zero, and the first access is accepted without waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | ADDR_W | CPU register address |
| busRd | input | 1 | CPU read strobe |
| busWr | input | 1 | CPU write strobe |
| busWdata | input | DATA_W | CPU write data |
| busRdata | output | DATA_W | Data returned by the last accepted read |
| epDirIn | input | 1 | Direction of the selected endpoint: 1 = transmit (IN), 0 = receive (OUT) |
| epByteMode | input | 1 | 1 = 8-bit access, 0 = 16-bit access |
| txPush | output | 1 | Push strobe to the transmit FIFO |
| txData | output | DATA_W | Word pushed into the transmit FIFO |
| txFull | input | 1 | Transmit FIFO is full |
| rxPop | output | 1 | Pop strobe to the receive FIFO |
| rxData | input | DATA_W | Head word of the receive FIFO |
| rxEmpty | input | 1 | Receive FIFO is empty |
| tooSoon | output | 1 | One-cycle flag: an access was rejected by the spacing rule |
| txOverflow | output | 1 | Sticky flag: a write hit a full transmit FIFO |

## Verification
The spacing check and the direction decode both act on the same strobe edge. A rejected access must therefore suppress whatever the direction decode would have done. The random stimulus uses idle gaps that straddle `MIN_GAP`, so early accesses land on full and empty FIFOs and on wrong-direction strobes. The bench then checks both results: `tooSoon` is raised, and there is no push, no pop, no `busRdata` change and no overflow. A second collision, two strobes rising together, is provoked on purpose. The bench judges it by which FIFO strobe fires, and by the next access being held off for the full gap.

// File: rtl/efpPkg.sv
package efpPkg;
  typedef struct packed {
    logic doPop;   // pop receive FIFO this cycle
    logic doPush;  // push transmit FIFO this cycle
    logic capRd;   // load read-data register
    logic setOvf;  // write hit a full transmit FIFO
  } strb_t;
endpackage

// File: rtl/efpCtrl.sv
module efpCtrl #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 8'h44,
  parameter int MIN_GAP = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic              epDirIn,
  input  logic              rxEmpty,
  input  logic              txFull,
  output efpPkg::strb_t     strb,
  output logic              tooSoon
);
  localparam int GAP_W = $clog2(MIN_GAP + 1);
  localparam logic [GAP_W-1:0] GAP_RELOAD = GAP_W'(MIN_GAP - 1);

  logic rdPrev, wrPrev;
  logic rdRise, wrRise, hit, req, open, acc;
  logic isRd, isWr;
  logic [GAP_W-1:0] gapCnt;

  assign rdRise = busRd && !rdPrev;
  assign wrRise = busWr && !wrPrev;
  assign hit    = (busAddr == PORT_ADDR);
  assign req    = hit && (rdRise || wrRise);
  assign open   = (gapCnt == '0);
  assign acc    = req && open;
  assign isRd   = acc && rdRise && !epDirIn;
  assign isWr   = acc && wrRise && epDirIn;

  always_comb begin
    strb.doPop  = isRd && !rxEmpty;
    strb.doPush = isWr && !txFull;
    strb.capRd  = acc && rdRise && !isWr;
    strb.setOvf = isWr && txFull;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPrev  <= 1'b0;
      wrPrev  <= 1'b0;
      gapCnt  <= '0;
      tooSoon <= 1'b0;
    end else begin
      rdPrev  <= busRd;
      wrPrev  <= busWr;
      tooSoon <= req && !open;
      if (acc) gapCnt <= GAP_RELOAD;
      else if (!open) gapCnt <= gapCnt - 1'b1;
    end
  end

  // independent spacing monitor
  logic [GAP_W-1:0] sinceAcc;
  logic seenAcc;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceAcc <= '0;
      seenAcc  <= 1'b0;
    end else if (acc) begin
      sinceAcc <= GAP_W'(1);
      seenAcc  <= 1'b1;
    end else if (sinceAcc != GAP_W'(MIN_GAP)) begin
      sinceAcc <= sinceAcc + 1'b1;
    end
  end

  AST_GAP_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (acc && seenAcc) |-> (sinceAcc >= GAP_W'(MIN_GAP))); // R6
  AST_ONE_PER_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doPush || strb.doPop) |=> !(strb.doPush || strb.doPop)); // R9
  AST_DIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.doPush && strb.doPop)); // R10
endmodule

// File: rtl/efpData.sv
module efpData #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  efpPkg::strb_t     strb,
  input  logic              epByteMode,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] rxData,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] txData,
  output logic              txOverflow
);
  localparam logic [DATA_W-1:0] FULL_MASK = '1;
  localparam logic [DATA_W-1:0] BYTE_MASK = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};

  logic [DATA_W-1:0] laneMask;
  assign laneMask = epByteMode ? BYTE_MASK : FULL_MASK;
  assign txData   = busWdata & laneMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdata   <= '0;
      txOverflow <= 1'b0;
    end else begin
      if (strb.capRd) busRdata <= strb.doPop ? (rxData & laneMask) : '0;
      if (strb.setOvf) txOverflow <= 1'b1;
    end
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    txOverflow |=> txOverflow); // R8
  AST_BYTE_PUSH_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doPush && epByteMode) |-> (txData[DATA_W-1:BYTE_W] == '0)); // R5
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capRd |=> $stable(busRdata)); // R1
endmodule

// File: rtl/efpPort.sv
module efpPort #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 8'h44,
  parameter int MIN_GAP = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              epDirIn,
  input  logic              epByteMode,
  output logic              txPush,
  output logic [DATA_W-1:0] txData,
  input  logic              txFull,
  output logic              rxPop,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxEmpty,
  output logic              tooSoon,
  output logic              txOverflow
);
  efpPkg::strb_t strb;

  efpCtrl #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR), .MIN_GAP(MIN_GAP)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .epDirIn(epDirIn), .rxEmpty(rxEmpty), .txFull(txFull),
    .strb(strb), .tooSoon(tooSoon)
  );

  efpData #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .epByteMode(epByteMode),
    .busWdata(busWdata), .rxData(rxData), .busRdata(busRdata),
    .txData(txData), .txOverflow(txOverflow)
  );

  assign txPush = strb.doPush;
  assign rxPop  = strb.doPop;

  AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    rxPop |-> (!rxEmpty && !epDirIn)); // R7
  AST_PUSH_NOT_FULL: assert property (@(posedge clk) disable iff (!rstN)
    txPush |-> (!txFull && epDirIn)); // R4
endmodule

// File: tb/efpPort_test.sv
`timescale 1ns/1ps
module efpPort_test;
  localparam int MIN_GAP = 50;
  localparam logic [7:0] PORT = 8'h44;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] busAddr = '0;
  logic busRd = 1'b0, busWr = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic epDirIn = 1'b0, epByteMode = 1'b0;
  logic txPush, rxPop, tooSoon, txOverflow;
  logic [15:0] txData;
  logic txFull = 1'b0;
  logic [15:0] rxData = '0;
  logic rxEmpty = 1'b1;

  int tests = 0, fails = 0;
  int edgeN = 0;
  int nextOk = 0;
  logic [15:0] expRd = '0;
  logic expOvf = 1'b0;
  logic [15:0] rxQ[$];

  efpPort #(.MIN_GAP(MIN_GAP)) uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .epDirIn(epDirIn),
    .epByteMode(epByteMode), .txPush(txPush), .txData(txData), .txFull(txFull),
    .rxPop(rxPop), .rxData(rxData), .rxEmpty(rxEmpty), .tooSoon(tooSoon),
    .txOverflow(txOverflow)
  );

  always #2 clk = ~clk;
  always @(posedge clk) edgeN <= edgeN + 1;

  function automatic logic [15:0] laneOf(input logic [15:0] d, input logic b);
    return b ? {8'h00, d[7:0]} : d;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic feedRx();
    rxEmpty = (rxQ.size() == 0);
    rxData  = rxEmpty ? 16'h0000 : rxQ[0];
  endtask

  // one access: strobes high for one edge, then one low edge
  task automatic access(input logic rd, input logic wr, input logic [7:0] a,
                        input logic [15:0] wd, input logic dir, input logic bm,
                        input logic full);
    logic hit, open, acc, isRd, isWr, expPush, expPop, expSoon;
    busAddr = a; busRd = rd; busWr = wr; busWdata = wd;
    epDirIn = dir; epByteMode = bm; txFull = full;
    feedRx();
    hit  = (a == PORT) && (rd || wr);
    open = (edgeN + 1 >= nextOk);
    acc  = hit && open;
    isRd = acc && rd && !dir;
    isWr = acc && wr && dir;
    expPush = isWr && !full;
    expPop  = isRd && !rxEmpty;
    expSoon = hit && !open;
    if (acc) nextOk = edgeN + 1 + MIN_GAP;
    if (acc && rd && !isWr) expRd = expPop ? laneOf(rxData, bm) : 16'h0000;
    if (isWr && full) expOvf = 1'b1;
    #1;
    chk("R3 push", {15'd0, txPush}, {15'd0, expPush});
    if (expPush) chk("R5/R3 txData", txData, laneOf(wd, bm));
    chk("R2 pop", {15'd0, rxPop}, {15'd0, expPop});
    @(posedge clk);
    @(negedge clk);
    if (expPop) void'(rxQ.pop_front());
    busRd = 1'b0; busWr = 1'b0;
    chk("R2/R4/R7 rdata", busRdata, expRd);
    chk("R6 tooSoon", {15'd0, tooSoon}, {15'd0, expSoon});
    chk("R8 overflow", {15'd0, txOverflow}, {15'd0, expOvf});
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int holdPush;
    void'($urandom(32'd20240611));
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 rdata", busRdata, 16'h0000);
    chk("R11 ovf", {15'd0, txOverflow}, 16'h0000);
    chk("R11 tooSoon", {15'd0, tooSoon}, 16'h0000);
    nextOk = 0;

    // R11 first access accepted at once, R2 full-width read
    rxQ.push_back(16'hBEEF);
    access(1, 0, PORT, 16'h0, 0, 0, 0);
    // R6 immediate second access rejected
    rxQ.push_back(16'h1234);
    access(1, 0, PORT, 16'h0, 0, 0, 0);
    idle(MIN_GAP);
    // R5 byte read
    access(1, 0, PORT, 16'h0, 0, 1, 0);
    idle(MIN_GAP);
    // R7 empty read
    access(1, 0, PORT, 16'h0, 0, 0, 0);
    idle(MIN_GAP);
    // R3 push, R5 byte push
    access(0, 1, PORT, 16'hA5C3, 1, 0, 0);
    idle(MIN_GAP);
    access(0, 1, PORT, 16'hFF7E, 1, 1, 0);
    idle(MIN_GAP);
    // R4 wrong directions
    rxQ.push_back(16'h0F0F);
    access(1, 0, PORT, 16'h0, 1, 0, 0);
    idle(MIN_GAP);
    access(0, 1, PORT, 16'h5555, 0, 0, 0);
    idle(MIN_GAP);
    // R1 other address
    access(1, 1, 8'h40, 16'h7777, 0, 0, 0);
    // R10 both strobes, IN then OUT
    access(1, 1, PORT, 16'h3C3C, 1, 0, 0);
    idle(MIN_GAP);
    access(1, 1, PORT, 16'h3C3C, 0, 0, 0);
    idle(MIN_GAP);
    // R8 overflow and stickiness
    access(0, 1, PORT, 16'h9999, 1, 0, 1);
    idle(MIN_GAP);
    access(0, 1, PORT, 16'h1111, 1, 0, 0);
    idle(MIN_GAP);

    // R9 held strobe yields one push
    busAddr = PORT; epDirIn = 1'b1; epByteMode = 1'b0; txFull = 1'b0;
    busWdata = 16'h4242; busWr = 1'b1;
    holdPush = 0;
    for (int i = 0; i < 4; i++) begin
      #1;
      if (txPush) holdPush++;
      @(negedge clk);
    end
    busWr = 1'b0;
    nextOk = edgeN + MIN_GAP;
    chk("R9 held strobe pushes", 16'(holdPush), 16'd1);
    idle(MIN_GAP);

    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [7:0] a;
      logic rd, wr;
      int kind;
      idle($urandom_range(0, MIN_GAP + 8));
      if (($urandom % 3) == 0 && rxQ.size() < 4) rxQ.push_back(16'($urandom));
      a = (($urandom % 8) == 0) ? 8'($urandom) : PORT;
      kind = $urandom % 5;
      rd = (kind == 0 || kind == 1 || kind == 4);
      wr = (kind == 2 || kind == 3 || kind == 4);
      access(rd, wr, a, 16'($urandom), 1'($urandom), 1'($urandom),
             (($urandom % 4) == 0));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule